// File: doc/BRIEF.md
# Bit Deposit and Extract Unit

This unit moves bits between a source word and a result word under the control of a mask. It has two operations. In deposit mode, the low-order bits of the source are spread out to the bit positions where the mask is one. In extract mode, the source bits at the positions where the mask is one are collected into the low-order bits of the result, packed together.

The unit is iterative. A start pulse captures the operands while the unit is idle. After that, the unit handles one set mask bit per clock cycle, lowest set bit first. A trailing-zero counter finds the position of that bit, and the unit then clears it from its working copy of the mask. A running index pairs each position with the next sequential bit. On the source side this pairing is used for deposit, and on the result side it is used for extract. When no mask bits remain, the result is registered and a one-cycle done pulse is raised.

As a side result, the unit also reports the trailing-zero count and the leading-zero count of the captured mask.

Top module: `bdx_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `result_o` is 0, and both `mask_tz_o` and `mask_lz_o` equal W.
- R2: A `start_i` sampled high while `busy_o` is 0 starts an operation, and `busy_o` reads 1 in the following cycle. A `start_i` sampled while `busy_o` is 1 is ignored, and the operation in flight finishes with its original operands.
- R3: With `op_i` = 0 (deposit), source bit k goes to the result bit at the position of the k-th lowest set mask bit, with k counted from 0.
- R4: With `op_i` = 1 (extract), the source bit at the position of the k-th lowest set mask bit goes to result bit k.
- R5: Every result bit that the operation does not write is 0. Nothing from an earlier result carries over.
- R6: If the start edge is cycle 0, `done_o` is high for exactly one cycle, after edge P+1, where P is the number of ones in the mask. `busy_o` falls at that same edge.
- R7: An all-zero mask gives a zero result, with `done_o` after edge 1.
- R8: From the cycle after an accepted start, `mask_tz_o` and `mask_lz_o` hold the trailing-zero and leading-zero counts of that operation's mask. Each count is W for an all-zero mask.
- R9: `result_o` changes only at the edge that raises `done_o`, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| op_i | input | 1 | 0 = deposit, 1 = extract |
| src_i | input | W | Source operand |
| mask_i | input | W | Mask operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Result of the last completed operation |
| mask_tz_o | output | $clog2(W+1) | Trailing zeros of the captured mask |
| mask_lz_o | output | $clog2(W+1) | Leading zeros of the captured mask |

## Verification
Both operations are run with a set of chosen masks:
- An all-zero mask checks the early exit and the W counts.
- An all-ones mask is the longest run, and in it each operation behaves as a plain copy.
- Single-bit masks at the bottom and at the top place the pairing index at its two extremes.
- Alternating masks check that the running index advances apart from the bit position.
- Random sources and masks check the general case, and the timing check against the count of ones catches any step that is skipped or repeated.

A sparse mask that follows a dense one exposes any leakage from the earlier result. A start pulse issued with different operands during a busy run shows whether restarts are ignored.

// File: rtl/bdx_pkg.sv
package bdx_pkg;

    typedef enum logic {
        BDX_DEPOSIT = 1'b0,
        BDX_EXTRACT = 1'b1
    } bdx_op_e;

endpackage

// File: rtl/bdx_tzc.sv
// Trailing-zero counter: index of the lowest one, or W when vec is zero.
module bdx_tzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    always_comb begin
        cnt_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                cnt_o = CW'(i);
            end
        end
    end

endmodule

// File: rtl/bdx_lzc.sv
// Leading-zero counter built by reversing the word into a trailing-zero counter.
module bdx_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    logic [W-1:0] rev;

    for (genvar g = 0; g < W; g++) begin : g_rev
        assign rev[g] = vec_i[W-1-g];
    end

    bdx_tzc #(.W(W), .CW(CW)) u_tzc (
        .vec_i (rev),
        .cnt_o (cnt_o)
    );

endmodule

// File: rtl/bdx_unit.sv
module bdx_unit
    import bdx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   op_i,
    input  logic [W-1:0]           src_i,
    input  logic [W-1:0]           mask_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [W-1:0]           result_o,
    output logic [$clog2(W+1)-1:0] mask_tz_o,
    output logic [$clog2(W+1)-1:0] mask_lz_o
);

    localparam int CW = $clog2(W + 1);
    localparam int IW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        bdx_op_e       op;
        logic [W-1:0]  src;
        logic [W-1:0]  rem;
        logic [W-1:0]  acc;
        logic [W-1:0]  res;
        logic [CW-1:0] cnt;
        logic [CW-1:0] tz;
        logic [CW-1:0] lz;
    } state_t;

    state_t st_q, st_d;

    logic [CW-1:0] step_tz_w;
    logic [CW-1:0] in_tz_w;
    logic [CW-1:0] in_lz_w;
    logic [IW-1:0] pos_w;
    logic [IW-1:0] idx_w;

    // Position of the lowest remaining mask bit.
    bdx_tzc #(.W(W), .CW(CW)) u_step_tz (.vec_i(st_q.rem), .cnt_o(step_tz_w));
    // Auxiliary counts on the incoming mask, captured at start.
    bdx_tzc #(.W(W), .CW(CW)) u_in_tz   (.vec_i(mask_i),   .cnt_o(in_tz_w));
    bdx_lzc #(.W(W), .CW(CW)) u_in_lz   (.vec_i(mask_i),   .cnt_o(in_lz_w));

    assign pos_w = step_tz_w[IW-1:0];
    assign idx_w = st_q.cnt[IW-1:0];

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.op   = bdx_op_e'(op_i);
                st_d.src  = src_i;
                st_d.rem  = mask_i;
                st_d.acc  = '0;
                st_d.cnt  = '0;
                st_d.tz   = in_tz_w;
                st_d.lz   = in_lz_w;
            end
        end else if (st_q.rem == '0) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.res  = st_q.acc;
        end else begin
            if (st_q.op == BDX_DEPOSIT) begin
                st_d.acc[pos_w] = st_q.src[idx_w];
            end else begin
                st_d.acc[idx_w] = st_q.src[pos_w];
            end
            st_d.rem = st_q.rem & (st_q.rem - 1'b1);
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.tz   <= CW'(W);
            st_q.lz   <= CW'(W);
        end else begin
            st_q      <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign result_o  = st_q.res;
    assign mask_tz_o = st_q.tz;
    assign mask_lz_o = st_q.lz;

    // R6: completion is a single-cycle pulse.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: busy falling always coincides with completion.
    assert_busy_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R2: an idle start makes the unit busy on the next cycle.
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2: a start while busy leaves the working operand untouched.
    assert_busy_ignores_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(st_q.rem == '0)) |=> $stable(st_q.src));

    // R9: the result moves only on completion.
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R5: a result never carries more ones than mask bits consumed.
    assert_result_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(result_o) <= int'(st_q.cnt)));

    // R6: the step index never passes the word width.
    assert_index_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (int'(st_q.cnt) <= W));

endmodule

// File: tb/bdx_unit_tb_top.sv
`timescale 1ns/1ps
module bdx_unit_tb_top;

    localparam int W  = 32;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_i = 1'b0;
    logic [W-1:0]  src_i = '0;
    logic [W-1:0]  mask_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [W-1:0]  result_o;
    logic [CW-1:0] mask_tz_o;
    logic [CW-1:0] mask_lz_o;

    always #2.5 clk = ~clk;

    bdx_unit #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .src_i     (src_i),
        .mask_i    (mask_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o),
        .mask_tz_o (mask_tz_o),
        .mask_lz_o (mask_lz_o)
    );

    typedef struct {
        logic [W-1:0] res;
        int           lat;
        int           tz;
        int           lz;
        int           t0;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    logic         prev_done = 1'b0;
    logic [W-1:0] last_res = '0;
    bit           summary_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    function automatic logic [W-1:0] ref_dep(logic [W-1:0] s, logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                r[i] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_ext(logic [W-1:0] s, logic [W-1:0] m);
        logic [W-1:0] r = '0;
        int k = 0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                r[k] = s[i];
                k++;
            end
        end
        return r;
    endfunction

    function automatic int ref_tz(logic [W-1:0] m);
        for (int i = 0; i < W; i++) if (m[i]) return i;
        return W;
    endfunction

    function automatic int ref_lz(logic [W-1:0] m);
        for (int i = W - 1; i >= 0; i--) if (m[i]) return W - 1 - i;
        return W;
    endfunction

    // Monitor: pops the scoreboard on each completion.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                chk(!done_o, "R6 done lasts one cycle", 64'(done_o), 64'd0);
            end
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected completion", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(result_o == e.res, {e.tag, " result"}, 64'(result_o), 64'(e.res));
                    chk((cyc - e.t0) == e.lat, "R6 latency", 64'(cyc - e.t0), 64'(e.lat));
                    chk(int'(mask_tz_o) == e.tz, "R8 trailing zeros", 64'(mask_tz_o), 64'(e.tz));
                    chk(int'(mask_lz_o) == e.lz, "R8 leading zeros", 64'(mask_lz_o), 64'(e.lz));
                    last_res = e.res;
                end
            end
            prev_done = done_o;
        end
    end

    // Driver: launches one operation and records what it should produce.
    // meddle = 1 drives a conflicting start during the busy phase.
    task automatic run_op(input bit op, input logic [W-1:0] s, input logic [W-1:0] m,
                          input bit meddle);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        start_i = 1'b1;
        op_i    = op;
        src_i   = s;
        mask_i  = m;
        e.res   = op ? ref_ext(s, m) : ref_dep(s, m);
        e.lat   = $countones(m) + 2;
        e.tz    = ref_tz(m);
        e.lz    = ref_lz(m);
        e.t0    = cyc;
        e.tag   = (m == '0) ? "R7 zero mask" : (op ? "R4 extract R5" : "R3 deposit R5");
        sb_q.push_back(e);
        @(negedge clk);
        chk(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
        if (meddle && busy_o) begin
            start_i = 1'b1;
            op_i    = ~op;
            src_i   = ~s;
            mask_i  = ~m;
            @(negedge clk);
        end
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk(busy_o == 0 && done_o == 0, "R1 reset handshake", {62'd0, busy_o, done_o}, 64'd0);
        chk(result_o == '0, "R1 reset result", 64'(result_o), 64'd0);
        chk(int'(mask_tz_o) == W && int'(mask_lz_o) == W, "R1 reset counts",
            64'(mask_tz_o), 64'(W));
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4 fixed patterns.
        run_op(1'b0, 32'h0000_00FF, 32'hF0F0_F0F0, 1'b0);
        run_op(1'b1, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 1'b0);
        run_op(1'b0, 32'h1234_5678, 32'hFFFF_FFFF, 1'b0);
        run_op(1'b1, 32'h8000_0001, 32'h8000_0001, 1'b0);
        run_op(1'b0, 32'h0000_0001, 32'h8000_0000, 1'b0);
        run_op(1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
        run_op(1'b1, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        run_op(1'b1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
        // R5: sparse after dense must not leak.
        run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run_op(1'b0, 32'h0000_0002, 32'h0001_0100, 1'b0);
        // R7: zero mask on both operations.
        run_op(1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
        run_op(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
        // R2: conflicting start during busy is ignored.
        run_op(1'b0, 32'h0000_0F0F, 32'h00FF_00FF, 1'b1);
        run_op(1'b1, 32'h1357_9BDF, 32'h0F0F_0F0F, 1'b1);

        // R9: result holds while idle.
        repeat (4) @(negedge clk);
        chk(result_o == last_res, "R9 result held", 64'(result_o), 64'(last_res));

        // Random coverage of R3 and R4.
        for (int n = 0; n < 200; n++) begin
            run_op(n[0], W'($urandom), W'($urandom) & W'($urandom), 1'b0);
        end

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R6 every start completed", 64'(sb_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule